// File: doc/BRIEF.md
# Analog-Memory Acquisition and Conversion Sequencer

This block sequences event storage into a cell-based analog sample memory serving 64 channels, then hands the stored cells over to a conversion phase. While a level-sensitive acquisition-enable input is high, every trigger claims the next free memory depth and records the 64-bit channel hit pattern beside it. A discard input erases the most recently claimed depth, so that depth no longer counts.

When acquisition-enable goes low, a busy line rises to tell the host that conversion is under way. The block then steps through the used depths in ascending order and presents each depth's index and hit pattern for a fixed, parameterizable number of cycles. After the last depth the busy line drops. The number of used depths and the resulting count of 16-bit data words stay on the outputs until the next acquisition begins. The analog sampling, the converter itself and readout serialisation are outside this block.

Top module: `amem_sequencer`

## Requirements
- R1: After reset the block is idle, with `depthCount` 0, `chipBusy` 0, `depthFull` 0 and `dataWords` 0.
- R2: Triggers are taken only while acquisition runs. A trigger seen while idle or converting leaves `depthCount` unchanged. An edge at which `startAcq` is sampled high while idle starts a new acquisition and clears `depthCount` to 0.
- R3: During acquisition, a trigger sampled with `startAcq` high stores `hitPattern` at depth index `depthCount` and increments `depthCount` by one.
- R4: During acquisition, `noTrigger` erases the most recently claimed depth and decrements `depthCount`. At a count of 0 it has no effect. When it arrives in the same cycle as an accepted trigger, the count is unchanged.
- R5: At most 15 depths are used. `depthFull` is 1 exactly when `depthCount` is 15, and a trigger at that point is ignored.
- R6: `chipBusy` rises at the edge where `startAcq` is first sampled low during acquisition. A trigger in that cycle is ignored.
- R7: With n > 0 used depths, `chipBusy` stays high for n × 4 cycles (4 is the `CONV_CYCLES` default). During that time `convIdx` counts 0 to n−1, each value held for 4 cycles, and `convHits` shows the pattern stored at that index. `depthCount` does not change while `chipBusy` is high.
- R8: With zero used depths, `chipBusy` is high for exactly one cycle.
- R9: `dataWords` equals `depthCount` × (2 × 64 + 2): one ID word and one bunch-crossing word per depth, plus a charge word and a time word per channel. It is 0 for zero depths. The count persists after conversion until the next acquisition starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startAcq | input | 1 | Acquisition enable, level-sensitive |
| trigger | input | 1 | Claim the next memory depth |
| noTrigger | input | 1 | Discard the latest claimed depth |
| hitPattern | input | 64 | Channel hit pattern stored with a trigger |
| chipBusy | output | 1 | High while conversion runs |
| depthCount | output | 4 | Number of used depths |
| depthFull | output | 1 | All depths used |
| dataWords | output | 11 | Data word count for the used depths |
| convIdx | output | 4 | Depth being converted (valid while busy) |
| convHits | output | 64 | Hit pattern of the depth being converted |

## Verification
Storing a depth and discarding a depth can fall in the same cycle, and so can the last accepted trigger and the full limit. Directed steps drive `trigger` and `noTrigger` together, both below the limit and at 15 used depths. The random phase raises both inputs with independent probabilities, so coincidences also happen at counts of 0 and 15. Each case is judged on `depthCount` one cycle later: unchanged below the limit, one lower when the memory is full, and still 0 when it was empty. The depth patterns replayed during conversion then show whether the surviving entries are the ones expected.

// File: rtl/amem_seq_pkg.sv
package amem_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  // strobes from the sequencer control to the depth datapath
  typedef struct packed {
    logic clrDepth;   // start of a new acquisition
    logic pushDepth;  // store pattern at current count, count up
    logic popDepth;   // erase latest depth, count down
  } depth_ctrl_t;

endpackage

// File: rtl/amem_seq_ctrl.sv
module amem_seq_ctrl
  import amem_seq_pkg::*;
#(
  parameter int MAX_DEPTHS  = 15,
  parameter int CONV_CYCLES = 4,
  parameter int DEPTH_W     = 4,
  parameter int SUB_W       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startAcq,
  input  logic               trigger,
  input  logic               noTrigger,
  input  logic [DEPTH_W-1:0] depthCount,
  output depth_ctrl_t        ctrl,
  output logic               busy,
  output logic               acqActive,
  output logic [DEPTH_W-1:0] convIdx
);

  seq_state_e        state;
  logic [SUB_W-1:0]  subCnt;
  logic              atLimit;
  logic              lastSub;
  logic              lastDepth;

  assign atLimit   = (depthCount == DEPTH_W'(MAX_DEPTHS));
  assign lastSub   = (subCnt == SUB_W'(CONV_CYCLES - 1));
  assign lastDepth = (convIdx == depthCount - DEPTH_W'(1));
  assign busy      = (state == ST_CONV);
  assign acqActive = (state == ST_ACQ);

  always_comb begin
    ctrl = '0;
    if (state == ST_IDLE && startAcq) begin
      ctrl.clrDepth = 1'b1;
    end else if (state == ST_ACQ && startAcq) begin
      ctrl.pushDepth = trigger && !atLimit;
      ctrl.popDepth  = noTrigger && ((depthCount != '0) || ctrl.pushDepth);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subCnt  <= '0;
      convIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startAcq) state <= ST_ACQ;
        end
        ST_ACQ: begin
          if (!startAcq) begin
            state   <= ST_CONV;
            subCnt  <= '0;
            convIdx <= '0;
          end
        end
        ST_CONV: begin
          if (depthCount == '0) begin
            state <= ST_IDLE;
          end else if (lastSub) begin
            subCnt <= '0;
            if (lastDepth) state <= ST_IDLE;
            else           convIdx <= convIdx + DEPTH_W'(1);
          end else begin
            subCnt <= subCnt + SUB_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amem_seq_data.sv
module amem_seq_data
  import amem_seq_pkg::*;
#(
  parameter int NUM_CHANNELS    = 64,
  parameter int MAX_DEPTHS      = 15,
  parameter int WORDS_PER_DEPTH = 130,
  parameter int DEPTH_W         = 4,
  parameter int WORDS_W         = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  depth_ctrl_t             ctrl,
  input  logic [NUM_CHANNELS-1:0] hitPattern,
  input  logic [DEPTH_W-1:0]      convIdx,
  output logic [DEPTH_W-1:0]      depthCount,
  output logic                    depthFull,
  output logic [WORDS_W-1:0]      dataWords,
  output logic [NUM_CHANNELS-1:0] convHits
);

  logic [NUM_CHANNELS-1:0] hitMem [MAX_DEPTHS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthCount <= '0;
    end else if (ctrl.clrDepth) begin
      depthCount <= '0;
    end else begin
      unique case ({ctrl.pushDepth, ctrl.popDepth})
        2'b10:   depthCount <= depthCount + DEPTH_W'(1);
        2'b01:   depthCount <= depthCount - DEPTH_W'(1);
        default: depthCount <= depthCount;
      endcase
    end
  end

  // one pattern register per memory depth
  for (genvar d = 0; d < MAX_DEPTHS; d++) begin : g_depth
    always_ff @(posedge clk) begin
      if (ctrl.pushDepth && depthCount == DEPTH_W'(d)) hitMem[d] <= hitPattern;
    end
  end

  assign convHits  = (convIdx < DEPTH_W'(MAX_DEPTHS)) ? hitMem[convIdx] : '0;
  assign depthFull = (depthCount == DEPTH_W'(MAX_DEPTHS));
  assign dataWords = WORDS_W'(depthCount) * WORDS_W'(WORDS_PER_DEPTH);

endmodule

// File: rtl/amem_sequencer.sv
module amem_sequencer
  import amem_seq_pkg::*;
#(
  parameter int NUM_CHANNELS = 64,
  parameter int MAX_DEPTHS   = 15,
  parameter int CONV_CYCLES  = 4,
  localparam int DEPTH_W         = $clog2(MAX_DEPTHS + 1),
  localparam int WORDS_PER_DEPTH = 2 * NUM_CHANNELS + 2,
  localparam int WORDS_W         = $clog2(MAX_DEPTHS * WORDS_PER_DEPTH + 1),
  localparam int SUB_W           = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startAcq,
  input  logic                    trigger,
  input  logic                    noTrigger,
  input  logic [NUM_CHANNELS-1:0] hitPattern,
  output logic                    chipBusy,
  output logic [DEPTH_W-1:0]      depthCount,
  output logic                    depthFull,
  output logic [WORDS_W-1:0]      dataWords,
  output logic [DEPTH_W-1:0]      convIdx,
  output logic [NUM_CHANNELS-1:0] convHits
);

  depth_ctrl_t depthCtrl;
  logic        acqActive;

  amem_seq_ctrl #(
    .MAX_DEPTHS (MAX_DEPTHS),
    .CONV_CYCLES(CONV_CYCLES),
    .DEPTH_W    (DEPTH_W),
    .SUB_W      (SUB_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startAcq  (startAcq),
    .trigger   (trigger),
    .noTrigger (noTrigger),
    .depthCount(depthCount),
    .ctrl      (depthCtrl),
    .busy      (chipBusy),
    .acqActive (acqActive),
    .convIdx   (convIdx)
  );

  amem_seq_data #(
    .NUM_CHANNELS   (NUM_CHANNELS),
    .MAX_DEPTHS     (MAX_DEPTHS),
    .WORDS_PER_DEPTH(WORDS_PER_DEPTH),
    .DEPTH_W        (DEPTH_W),
    .WORDS_W        (WORDS_W)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (depthCtrl),
    .hitPattern(hitPattern),
    .convIdx   (convIdx),
    .depthCount(depthCount),
    .depthFull (depthFull),
    .dataWords (dataWords),
    .convHits  (convHits)
  );

endmodule

// File: rtl/amem_seq_checker.sv
module amem_seq_checker #(
  parameter int MAX_DEPTHS = 15,
  parameter int DEPTH_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               startAcq,
  input logic               trigger,
  input logic               noTrigger,
  input logic               acqActive,
  input logic               chipBusy,
  input logic               depthFull,
  input logic [DEPTH_W-1:0] depthCount
);

  a_r5_depth_cap: assert property (@(posedge clk) disable iff (!rstN)
    depthCount <= DEPTH_W'(MAX_DEPTHS));

  a_r5_full_ignores: assert property (@(posedge clk) disable iff (!rstN)
    acqActive && startAcq && depthFull && trigger && !noTrigger |=> depthCount == $past(depthCount));

  a_r3_push: assert property (@(posedge clk) disable iff (!rstN)
    acqActive && startAcq && trigger && !noTrigger && !depthFull |=> depthCount == $past(depthCount) + DEPTH_W'(1));

  a_r4_erase: assert property (@(posedge clk) disable iff (!rstN)
    acqActive && startAcq && noTrigger && !trigger && depthCount != '0 |=> depthCount == $past(depthCount) - DEPTH_W'(1));

  a_r4_coincide: assert property (@(posedge clk) disable iff (!rstN)
    acqActive && startAcq && noTrigger && trigger && !depthFull |=> $stable(depthCount));

  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    acqActive && !startAcq |=> chipBusy);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    chipBusy |=> $stable(depthCount));

  a_r8_empty_conv: assert property (@(posedge clk) disable iff (!rstN)
    chipBusy && depthCount == '0 |=> !chipBusy);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !acqActive && !chipBusy && !startAcq |=> $stable(depthCount));

endmodule

bind amem_sequencer amem_seq_checker #(
  .MAX_DEPTHS(MAX_DEPTHS),
  .DEPTH_W   (DEPTH_W)
) i_amem_seq_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startAcq  (startAcq),
  .trigger   (trigger),
  .noTrigger (noTrigger),
  .acqActive (acqActive),
  .chipBusy  (chipBusy),
  .depthFull (depthFull),
  .depthCount(depthCount)
);

// File: tb/test_amem_sequencer.sv
`timescale 1ns/1ps
module test_amem_sequencer;

  localparam int CH   = 64;
  localparam int MAXD = 15;
  localparam int K    = 4;
  localparam int WPD  = 2 * CH + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startAcq = 1'b0;
  logic          trigger = 1'b0;
  logic          noTrigger = 1'b0;
  logic [CH-1:0] hitPattern = '0;
  logic          chipBusy;
  logic [3:0]    depthCount;
  logic          depthFull;
  logic [10:0]   dataWords;
  logic [3:0]    convIdx;
  logic [CH-1:0] convHits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int            mState = 0;   // 0 idle, 1 acquiring, 2 converting
  int            mCount = 0;
  int            mIdx = 0;
  int            mSub = 0;
  logic [CH-1:0] mMem [MAXD];

  always #2 clk = ~clk;

  amem_sequencer i_amem_sequencer (
    .clk(clk), .rstN(rstN), .startAcq(startAcq), .trigger(trigger),
    .noTrigger(noTrigger), .hitPattern(hitPattern), .chipBusy(chipBusy),
    .depthCount(depthCount), .depthFull(depthFull), .dataWords(dataWords),
    .convIdx(convIdx), .convHits(convHits)
  );

  task automatic chk(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelTick(input bit sa, input bit tr, input bit nt, input logic [CH-1:0] hp);
    int n;
    bit add;
    case (mState)
      0: if (sa) begin mState = 1; mCount = 0; end
      1: begin
        if (!sa) begin
          mState = 2; mIdx = 0; mSub = 0;
        end else begin
          add = tr && (mCount < MAXD);
          if (add) mMem[mCount] = hp;
          n = mCount + int'(add);
          if (nt && n > 0) n--;
          mCount = n;
        end
      end
      default: begin
        if (mCount == 0) mState = 0;
        else if (mSub == K - 1) begin
          mSub = 0;
          if (mIdx == mCount - 1) mState = 0; else mIdx++;
        end else mSub++;
      end
    endcase
  endtask

  task automatic compareAll();
    chk("R6 chipBusy", CH'(chipBusy), CH'(mState == 2));
    chk("R3 depthCount", CH'(depthCount), CH'(mCount));
    chk("R5 depthFull", CH'(depthFull), CH'(mCount == MAXD));
    chk("R9 dataWords", CH'(dataWords), CH'(mCount * WPD));
    if (mState == 2 && mCount > 0) begin
      chk("R7 convIdx", CH'(convIdx), CH'(mIdx));
      chk("R7 convHits", convHits, mMem[mIdx]);
    end
  endtask

  // called at a falling edge: drive, let one rising edge pass, compare
  task automatic step(input bit sa, input bit tr, input bit nt, input logic [CH-1:0] hp);
    startAcq = sa; trigger = tr; noTrigger = nt; hitPattern = hp;
    @(posedge clk);
    modelTick(sa, tr, nt, hp);
    @(negedge clk);
    compareAll();
  endtask

  function automatic logic [CH-1:0] rndPat();
    return {$urandom(), $urandom()};
  endfunction

  // drop startAcq and return the number of sampled busy cycles
  task automatic runConversion(output int nBusy);
    nBusy = 0;
    step(1'b0, 1'b1, 1'b0, rndPat());   // trigger here must be ignored (R6)
    while (chipBusy) begin
      nBusy++;
      step(1'b0, 1'b0, 1'b0, '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb;
    int prev;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 chipBusy", CH'(chipBusy), '0);
    chk("R1 depthCount", CH'(depthCount), '0);
    chk("R1 depthFull", CH'(depthFull), '0);
    chk("R1 dataWords", CH'(dataWords), '0);

    // R2: triggers while idle are ignored
    repeat (3) step(1'b0, 1'b1, 1'b0, rndPat());
    chk("R2 idle trigger", CH'(depthCount), '0);

    // R3, R4: three triggers, erase, then coincident trigger and erase
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, 64'hA5A5_0000_0000_0001);
    step(1'b1, 1'b1, 1'b0, 64'h0000_FFFF_0000_0002);
    step(1'b1, 1'b1, 1'b0, 64'h8000_0000_1234_5678);
    chk("R3 three triggers", CH'(depthCount), CH'(3));
    step(1'b1, 1'b0, 1'b1, '0);
    chk("R4 erase", CH'(depthCount), CH'(2));
    step(1'b1, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0000);
    chk("R4 coincident", CH'(depthCount), CH'(2));
    runConversion(nb);
    chk("R7 busy length", CH'(nb), CH'(2 * K));
    chk("R9 words after conversion", CH'(dataWords), CH'(2 * WPD));

    // R2: busy start with startAcq high during conversion is ignored, then new acquisition clears
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R2 cleared on start", CH'(depthCount), '0);
    step(1'b1, 1'b1, 1'b0, rndPat());
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, rndPat());
    chk("R2 trigger in conversion", CH'(depthCount), CH'(1));
    while (chipBusy) step(1'b0, 1'b0, 1'b0, '0);

    // R8: zero used depths
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, '0);
    chk("R4 erase at zero", CH'(depthCount), '0);
    step(1'b1, 1'b1, 1'b1, rndPat());
    chk("R4 coincident at zero", CH'(depthCount), '0);
    step(1'b0, 1'b0, 1'b0, '0);
    nb = 0;
    while (chipBusy) begin nb++; step(1'b0, 1'b0, 1'b0, '0); end
    chk("R8 busy one cycle", CH'(nb), CH'(1));
    chk("R9 zero words", CH'(dataWords), '0);

    // R5: fill beyond the limit, then coincident inputs at the limit
    step(1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i < MAXD + 2; i++) step(1'b1, 1'b1, 1'b0, rndPat());
    chk("R5 capped count", CH'(depthCount), CH'(MAXD));
    chk("R5 full flag", CH'(depthFull), CH'(1));
    step(1'b1, 1'b1, 1'b1, rndPat());
    chk("R5 coincident when full", CH'(depthCount), CH'(MAXD - 1));
    runConversion(nb);
    chk("R7 busy length full", CH'(nb), CH'((MAXD - 1) * K));

    // random acquisitions
    for (int it = 0; it < 60; it++) begin
      for (int g = 0; g < int'($urandom_range(3)); g++)
        step(1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)), rndPat());
      step(1'b1, 1'b0, 1'b0, '0);
      for (int c = 0; c < int'($urandom_range(30)); c++) begin
        prev = mCount;
        step(1'b1, ($urandom_range(99) < 55), ($urandom_range(99) < 15), rndPat());
      end
      runConversion(nb);
      chk("R7 random busy length", CH'(nb), CH'((mCount == 0) ? 1 : mCount * K));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule